// File: doc/BRIEF.md
# Two-Mode Output Byte Stager

This block sits between a DMA-side write port and an 8-bit parallel peripheral bus and holds outgoing bytes until the bus side takes them. It has two transfer modes.

In synchronous mode a byte passes through two registers before it reaches the bus. It first lands in a host-visible latch, then moves into a hidden second-stage register, and the bus is driven from that second register. In asynchronous mode the second stage is bypassed, so the bus is driven straight from the latch and the hidden register is never loaded.

Each stage exports a full flag, so that after a transfer error software can tell how many bytes are still held inside. A flush input empties both stages. A change of mode takes effect only once both stages are empty.

Top module: `out_stage_buf`

## Requirements
- R1: After a synchronous reset, `latch_full`, `hold_full`, `bus_valid` and `mode_sync` are 0, `wr_ready` is 1 and `status` is 8'h00.
- R2: In asynchronous mode (`mode_sync`=0), a byte accepted at a clock edge is on `bus_data` with `bus_valid`=1 right after that edge, and `hold_full` stays 0.
- R3: In synchronous mode (`mode_sync`=1), an accepted byte sets `latch_full` at the first edge. At the second edge it moves to the hidden stage: `hold_full`=1, `latch_full`=0, and `bus_valid`=1 with the byte on `bus_data`.
- R4: `wr_ready` is 0 while the latch is full and is not being emptied in the same cycle. A write presented while `wr_ready` is 0 is dropped, and the held byte is not overwritten.
- R5: In synchronous mode with `bus_ack` held at 1, the latch refills in the same cycle it passes its byte on. `wr_ready` stays 1, and one byte per cycle reaches the bus in write order.
- R6: A stage's full flag clears at the edge where its byte is consumed: the latch's when the byte moves on, and the bus-facing stage's when `bus_valid` and `bus_ack` are both 1.
- R7: `status` bit 5 mirrors `latch_full` and bit 6 mirrors `hold_full`. All other bits are 0.
- R8: `flush`=1 at an edge empties both stages. Any write offered in that cycle is dropped, and `wr_ready` is 0 while `flush` is 1.
- R9: `mode_sync` follows `mode_req` only at an edge where both stages are empty. A request made earlier is held until then.
- R10: While `bus_valid`=1 and `bus_ack`=0, `bus_data` and `bus_valid` hold their values at the next edge (flush aside).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Empties both stages |
| mode_req | input | 1 | Requested mode, 1 = synchronous |
| wr_valid | input | 1 | Host offers a byte |
| wr_data | input | W | Byte from the host side |
| wr_ready | output | 1 | Latch can take a byte this cycle |
| bus_ack | input | 1 | Bus side takes the presented byte |
| bus_valid | output | 1 | A byte is presented to the bus |
| bus_data | output | W | Byte driven to the bus |
| latch_full | output | 1 | Visible latch holds a byte |
| hold_full | output | 1 | Hidden stage holds a byte |
| mode_sync | output | 1 | Mode in force, 1 = synchronous |
| status | output | 8 | Occupancy byte (bit 5 latch, bit 6 hidden) |

## Verification
The block is driven with the following input patterns:

- A single byte in each mode, with the bus stalled, shows whether the path is one register deep or two.
- A stalled write against a full latch separates a correctly blocked write from one that overwrites the held byte.
- A continuous synchronous stream with the acknowledge held high exposes any bubble in the hand-off from latch to hidden stage, and any reordering.
- Filling both stages and then flushing them checks the status bits.
- A mode request made while a byte is in flight checks that the switch is deferred until the stages are empty.

// File: rtl/out_stage_buf.sv
module out_stage_buf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         mode_req,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wr_ready,
  input  logic         bus_ack,
  output logic         bus_valid,
  output logic [W-1:0] bus_data,
  output logic         latch_full,
  output logic         hold_full,
  output logic         mode_sync,
  output logic [7:0]   status
);
  localparam int LATCH_BIT = 5;
  localparam int HOLD_BIT  = 6;

  logic [W-1:0] latch_q, hold_q;
  logic bus_fire, hold_load, latch_take, wr_fire;

  assign bus_valid  = mode_sync ? hold_full : latch_full;
  assign bus_data   = mode_sync ? hold_q : latch_q;
  assign bus_fire   = bus_valid & bus_ack;
  assign hold_load  = mode_sync & latch_full & (~hold_full | bus_fire);
  assign latch_take = mode_sync ? hold_load : (latch_full & bus_ack);
  assign wr_ready   = ~flush & (~latch_full | latch_take);
  assign wr_fire    = wr_valid & wr_ready;

  always_comb begin
    status = 8'h00;
    status[LATCH_BIT] = latch_full;
    status[HOLD_BIT]  = hold_full;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      latch_full <= 1'b0;
    end else if (wr_fire) begin
      latch_full <= 1'b1;
    end else if (latch_take) begin
      latch_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire) latch_q <= wr_data;
    if (hold_load) hold_q <= latch_q;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      hold_full <= 1'b0;
    end else if (hold_load) begin
      hold_full <= 1'b1;
    end else if (mode_sync && bus_fire) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_sync <= 1'b0;
    end else if (!latch_full && !hold_full) begin
      mode_sync <= mode_req;
    end
  end
endmodule

// File: rtl/out_stage_buf_chk.sv
module out_stage_buf_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         flush,
  input logic         wr_ready,
  input logic         bus_ack,
  input logic         bus_valid,
  input logic [W-1:0] bus_data,
  input logic         latch_full,
  input logic         hold_full,
  input logic         mode_sync
);
  // R4
  blocked_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_ready && !flush |-> latch_full);

  // R2
  async_no_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_sync |-> !hold_full);

  // R10
  stall_stable_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_ack && !flush |=> bus_valid && $stable(bus_data));

  // R9
  mode_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    latch_full || hold_full |=> $stable(mode_sync));

  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !latch_full && !hold_full && !bus_valid);
endmodule

bind out_stage_buf out_stage_buf_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .wr_ready(wr_ready),
  .bus_ack(bus_ack), .bus_valid(bus_valid), .bus_data(bus_data),
  .latch_full(latch_full), .hold_full(hold_full), .mode_sync(mode_sync)
);

// File: tb/tb_out_stage_buf.sv
module tb_out_stage_buf;
  logic       clk = 0, rst = 1, flush = 0, mode_req = 0;
  logic       wr_valid = 0, bus_ack = 0;
  logic [7:0] wr_data = 0;
  logic       wr_ready, bus_valid, latch_full, hold_full, mode_sync;
  logic [7:0] bus_data, status;
  int errors = 0, checks = 0;

  out_stage_buf dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset(input logic m);
    rst = 1; mode_req = m; wr_valid = 0; bus_ack = 0; flush = 0;
    step(); step();
    rst = 0;
    step(); step();
  endtask

  task automatic t_reset();
    rst = 1; step(); step();
    chk("R1 latch_full", latch_full, 0);
    chk("R1 hold_full", hold_full, 0);
    chk("R1 bus_valid", bus_valid, 0);
    chk("R1 wr_ready", wr_ready, 1);
    chk("R1 mode", mode_sync, 0);
    chk("R1 status", status, 8'h00);
    rst = 0;
  endtask

  task automatic t_async();
    do_reset(0);
    wr_valid = 1; wr_data = 8'hA5;
    step();
    wr_valid = 0;
    chk("R2 bus_valid", bus_valid, 1);
    chk("R2 bus_data", bus_data, 8'hA5);
    chk("R2 hold_full", hold_full, 0);
    chk("R7 status", status, 8'h20);
    // R4: blocked write does not overwrite
    wr_valid = 1; wr_data = 8'h11; #1;
    chk("R4 wr_ready", wr_ready, 0);
    step();
    wr_valid = 0;
    chk("R4 data kept", bus_data, 8'hA5);
    chk("R10 valid kept", bus_valid, 1);
    bus_ack = 1;
    step();
    bus_ack = 0;
    chk("R6 latch cleared", latch_full, 0);
    chk("R6 bus_valid", bus_valid, 0);
  endtask

  task automatic t_sync();
    do_reset(1);
    chk("R9 mode sync", mode_sync, 1);
    wr_valid = 1; wr_data = 8'h3C;
    step();
    wr_valid = 0;
    chk("R3 latch first", latch_full, 1);
    chk("R3 no bus yet", bus_valid, 0);
    step();
    chk("R3 hold_full", hold_full, 1);
    chk("R3 latch empty", latch_full, 0);
    chk("R3 bus_valid", bus_valid, 1);
    chk("R3 bus_data", bus_data, 8'h3C);
    chk("R7 status", status, 8'h40);
    bus_ack = 1;
    step();
    bus_ack = 0;
    chk("R6 hold cleared", hold_full, 0);
  endtask

  task automatic t_stream();
    do_reset(1);
    bus_ack = 1;
    for (int i = 0; i < 10; i++) begin
      wr_valid = (i < 6); wr_data = 8'h40 + 8'(i); #1;
      if (i < 6) chk("R5 wr_ready", wr_ready, 1);
      if (i >= 2 && i < 8) begin
        chk("R5 bus_valid", bus_valid, 1);
        chk("R5 order", bus_data, 8'h40 + 8'(i - 2));
      end
      step();
    end
    wr_valid = 0; bus_ack = 0;
    chk("R5 drained", status, 8'h00);
  endtask

  task automatic t_flush();
    do_reset(1);
    wr_valid = 1; wr_data = 8'h01;
    step();
    wr_data = 8'h02;
    step();
    wr_valid = 0;
    chk("R7 both full", status, 8'h60);
    chk("R8 hold data", bus_data, 8'h01);
    flush = 1; wr_valid = 1; wr_data = 8'h77; #1;
    chk("R8 ready low", wr_ready, 0);
    step();
    flush = 0; wr_valid = 0;
    chk("R8 latch", latch_full, 0);
    chk("R8 hold", hold_full, 0);
    chk("R8 bus_valid", bus_valid, 0);
  endtask

  task automatic t_mode();
    do_reset(0);
    wr_valid = 1; wr_data = 8'h99;
    step();
    wr_valid = 0; mode_req = 1;
    step(); step();
    chk("R9 deferred", mode_sync, 0);
    bus_ack = 1;
    step();
    bus_ack = 0;
    chk("R9 still old", mode_sync, 0);
    step();
    chk("R9 switched", mode_sync, 1);
  endtask

  initial begin
    step();
    t_reset();
    t_async();
    t_sync();
    t_stream();
    t_flush();
    t_mode();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule